// File: doc/BRIEF.md
# Evicted Dirty-Line Writeback Buffer

This block parks dirty cache lines that have been pushed out of a cache until a memory controller can take them. A victim line arrives as one full-width transfer of 512 bits together with its line address. It is written into one of eight slots. The data half of each slot sits in a plain storage array. The address half sits in a small content-addressable section. The oldest slot is streamed to memory over a 64-bit ready/valid port, one beat per accepted cycle. The stream starts with the least significant 64 bits and runs eight beats per line.

The cache can evict lines faster than memory can absorb them, so the buffer reports when all slots are occupied and refuses further loads at that point. Requests that come into the cache present their line address to the compare port every cycle. If a resident slot holds the same line, the requester gets a hit and must stall until that slot has completely left the buffer.

Top module: `evict_wb_buffer`

## Requirements
- R1: While reset is low and in the first cycle after it, `empty` is 1, `full` is 0, `mem_valid` is 0 and `lookup_hit` is 0.
- R2: A load (`fill_valid` high while `full` is low) is taken at the clock edge. After the first load following reset, that line is in slot 0 and `lookup_match` is 8'b0000_0001 for its address. Later loads take slots 1, 2, … in circular order.
- R3: `full` is 1 exactly when eight lines are resident, and `empty` is 1 exactly when none are. A load presented while `full` is 1 is dropped: its address never matches and it is never drained.
- R4: Lines leave in the order they were loaded. `mem_valid` is 1 whenever at least one line is resident, and `mem_addr` gives the line address of the oldest resident line.
- R5: Beat k (k = 0..7, shown on `mem_beat`) carries bits [64k+63:64k] of the line. `mem_last` is 1 only on beat 7. The beat advances only when `mem_valid` and `mem_ready` are both high.
- R6: While `mem_valid` is 1 and `mem_ready` is 0, `mem_data`, `mem_addr` and `mem_beat` hold their values into the next cycle.
- R7: `lookup_match[i]` is 1 when slot i is resident and holds the address on `lookup_addr`. The compare is combinational. `lookup_hit` is the OR of all the match bits.
- R8: A line that is being loaded in the current cycle takes no part in that cycle's compare.
- R9: A slot stays resident, and keeps matching, up to and including the cycle in which its beat 7 is accepted. From the following cycle on it no longer matches.
- R10: If a load is presented while `full` is 1 in the same cycle that beat 7 is accepted, the load is still refused. After the edge, `full` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Load request for an evicted line |
| fill_addr | input | 34 | Line address of the evicted line |
| fill_data | input | 512 | Full line contents |
| full | output | 1 | All eight slots are occupied; loads are refused |
| empty | output | 1 | No slot is occupied |
| lookup_addr | input | 34 | Line address compared against resident slots |
| lookup_match | output | 8 | Per-slot compare result |
| lookup_hit | output | 1 | Any slot matched |
| mem_valid | output | 1 | A beat is offered to memory |
| mem_ready | input | 1 | Memory accepts the offered beat |
| mem_addr | output | 34 | Line address of the line being drained |
| mem_beat | output | 3 | Index of the offered beat |
| mem_last | output | 1 | Offered beat is the final one of the line |
| mem_data | output | 64 | Beat payload |

## Verification
The bench first fills the buffer with memory stalled. This separates slot allocation and the compare result from any draining. The buffer is then loaded to capacity with one extra line offered, which shows whether a load is refused when full. Draining runs under an irregular ready pattern. This pattern separates beat ordering and the hold-while-stalled behaviour from an advance on every cycle. A lookup that tracks the head address shows the exact cycle in which a slot stops matching. A long mixed run then uses random loads, random back-pressure and a small pool of addresses that repeat. This forces loads and final beats to coincide and places duplicate lines in several slots. The whole run is compared cycle by cycle with a queue model.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
    localparam int unsigned WBB_SLOTS     = 8;
    localparam int unsigned WBB_LINE_BITS = 512;
    localparam int unsigned WBB_BEAT_BITS = 64;
    localparam int unsigned WBB_ADDR_BITS = 34;
endpackage

// File: rtl/wbb_ctrl.sv
// Slot pointers, occupancy and beat sequencing for the writeback buffer.
module wbb_ctrl #(
    parameter int unsigned SLOTS = 8,
    parameter int unsigned BEATS = 8,
    localparam int unsigned IDX_W = $clog2(SLOTS),
    localparam int unsigned BCT_W = $clog2(BEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_valid,
    input  logic             mem_ready,
    output logic             alloc,
    output logic [IDX_W-1:0] alloc_idx,
    output logic             drain_done,
    output logic [IDX_W-1:0] head_idx,
    output logic [BCT_W-1:0] beat_idx,
    output logic             mem_valid,
    output logic             full,
    output logic             empty
);
    localparam int unsigned CNT_W = $clog2(SLOTS + 1);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(SLOTS - 1);
    localparam logic [BCT_W-1:0] LAST_BEAT = BCT_W'(BEATS - 1);

    typedef struct packed {
        logic [IDX_W-1:0] wr;
        logic [IDX_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic [BCT_W-1:0] beat;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic  fire;

    always_comb begin
        s_d        = s_q;
        full       = (s_q.cnt == CNT_W'(SLOTS));
        empty      = (s_q.cnt == '0);
        mem_valid  = !empty;
        alloc      = fill_valid && !full;
        fire       = mem_valid && mem_ready;
        drain_done = fire && (s_q.beat == LAST_BEAT);

        if (fire) begin
            s_d.beat = drain_done ? '0 : s_q.beat + 1'b1;
        end
        if (drain_done) begin
            s_d.rd = (s_q.rd == LAST_IDX) ? '0 : s_q.rd + 1'b1;
        end
        if (alloc) begin
            s_d.wr = (s_q.wr == LAST_IDX) ? '0 : s_q.wr + 1'b1;
        end
        unique case ({alloc, drain_done})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign alloc_idx = s_q.wr;
    assign head_idx  = s_q.rd;
    assign beat_idx  = s_q.beat;
endmodule

// File: rtl/wbb_cam.sv
// Address section: per-slot line address plus residency bit, compared in parallel.
module wbb_cam #(
    parameter int unsigned SLOTS  = 8,
    parameter int unsigned ADDR_W = 34,
    localparam int unsigned IDX_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic [ADDR_W-1:0] cmp_addr,
    output logic [SLOTS-1:0]  cmp_match,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_addr
);
    logic [SLOTS-1:0]  live_d, live_q;
    logic [ADDR_W-1:0] tag_d [SLOTS];
    logic [ADDR_W-1:0] tag_q [SLOTS];

    always_comb begin
        live_d = live_q;
        for (int i = 0; i < SLOTS; i++) begin
            tag_d[i] = tag_q[i];
        end
        if (clr_en) begin
            live_d[clr_idx] = 1'b0;
        end
        if (set_en) begin
            live_d[set_idx] = 1'b1;
            tag_d[set_idx]  = set_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
        end else begin
            live_q <= live_d;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < SLOTS; i++) begin
            tag_q[i] <= tag_d[i];
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign cmp_match[g] = live_q[g] && (tag_q[g] == cmp_addr);
    end

    assign rd_addr = tag_q[rd_idx];
endmodule

// File: rtl/wbb_data.sv
// Line storage: whole-line write, beat-wide read.
module wbb_data #(
    parameter int unsigned SLOTS  = 8,
    parameter int unsigned LINE_W = 512,
    parameter int unsigned BEAT_W = 64,
    localparam int unsigned BEATS = LINE_W / BEAT_W,
    localparam int unsigned IDX_W = $clog2(SLOTS),
    localparam int unsigned BCT_W = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [BCT_W-1:0]  rd_beat,
    output logic [BEAT_W-1:0] rd_data
);
    logic [LINE_W-1:0] line_q [SLOTS];
    logic [BEAT_W-1:0] beats [BEATS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_q[wr_idx] <= wr_line;
        end
    end

    for (genvar b = 0; b < BEATS; b++) begin : g_beat
        assign beats[b] = line_q[rd_idx][b*BEAT_W +: BEAT_W];
    end

    assign rd_data = beats[rd_beat];
endmodule

// File: rtl/evict_wb_buffer.sv
module evict_wb_buffer
    import wbb_pkg::*;
#(
    parameter int unsigned SLOTS  = WBB_SLOTS,
    parameter int unsigned LINE_W = WBB_LINE_BITS,
    parameter int unsigned BEAT_W = WBB_BEAT_BITS,
    parameter int unsigned ADDR_W = WBB_ADDR_BITS,
    localparam int unsigned BEATS = LINE_W / BEAT_W,
    localparam int unsigned IDX_W = $clog2(SLOTS),
    localparam int unsigned BCT_W = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [LINE_W-1:0] fill_data,
    output logic              full,
    output logic              empty,
    input  logic [ADDR_W-1:0] lookup_addr,
    output logic [SLOTS-1:0]  lookup_match,
    output logic              lookup_hit,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BCT_W-1:0]  mem_beat,
    output logic              mem_last,
    output logic [BEAT_W-1:0] mem_data
);
    logic             alloc;
    logic             drain_done;
    logic [IDX_W-1:0] alloc_idx;
    logic [IDX_W-1:0] head_idx;

    wbb_ctrl #(.SLOTS(SLOTS), .BEATS(BEATS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_valid (fill_valid),
        .mem_ready  (mem_ready),
        .alloc      (alloc),
        .alloc_idx  (alloc_idx),
        .drain_done (drain_done),
        .head_idx   (head_idx),
        .beat_idx   (mem_beat),
        .mem_valid  (mem_valid),
        .full       (full),
        .empty      (empty)
    );

    wbb_cam #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_cam (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (alloc),
        .set_idx   (alloc_idx),
        .set_addr  (fill_addr),
        .clr_en    (drain_done),
        .clr_idx   (head_idx),
        .cmp_addr  (lookup_addr),
        .cmp_match (lookup_match),
        .rd_idx    (head_idx),
        .rd_addr   (mem_addr)
    );

    wbb_data #(.SLOTS(SLOTS), .LINE_W(LINE_W), .BEAT_W(BEAT_W)) u_data (
        .clk     (clk),
        .wr_en   (alloc),
        .wr_idx  (alloc_idx),
        .wr_line (fill_data),
        .rd_idx  (head_idx),
        .rd_beat (mem_beat),
        .rd_data (mem_data)
    );

    assign lookup_hit = |lookup_match;
    assign mem_last   = mem_valid && (mem_beat == BCT_W'(BEATS - 1));
endmodule

// File: rtl/wbb_checker.sv
module wbb_checker #(
    parameter int unsigned SLOTS  = 8,
    parameter int unsigned BCT_W  = 3,
    parameter int unsigned ADDR_W = 34,
    parameter int unsigned BEAT_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              full,
    input logic              empty,
    input logic              lookup_hit,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_last,
    input logic [BCT_W-1:0]  mem_beat,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [BEAT_W-1:0] mem_data
);
    // R1: an empty buffer offers nothing to memory and matches nothing
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (!mem_valid && !lookup_hit));

    // R3: the two status flags never coincide
    p_status_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R3: with no line leaving, a full buffer stays full
    p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !(mem_valid && mem_ready && mem_last)) |=> full);

    // R5: an accepted non-final beat is followed by the next beat of the same line
    p_beat_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && !mem_last) |=>
            (mem_valid && mem_beat == $past(mem_beat) + 1'b1 && $stable(mem_addr)));

    // R6: a stalled beat is held unchanged
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_data) && $stable(mem_addr) && $stable(mem_beat)));

    // R9 / R10: completing a line always leaves room
    p_last_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && mem_last) |=> !full);
endmodule

bind evict_wb_buffer wbb_checker #(
    .SLOTS(SLOTS), .BCT_W(BCT_W), .ADDR_W(ADDR_W), .BEAT_W(BEAT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .full       (full),
    .empty      (empty),
    .lookup_hit (lookup_hit),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_last   (mem_last),
    .mem_beat   (mem_beat),
    .mem_addr   (mem_addr),
    .mem_data   (mem_data)
);

// File: tb/evict_wb_buffer_tb.sv
module evict_wb_buffer_tb;
    localparam int N  = 8;
    localparam int LW = 512;
    localparam int BW = 64;
    localparam int AW = 34;
    localparam int NB = LW / BW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          fill_valid;
    logic [AW-1:0] fill_addr;
    logic [LW-1:0] fill_data;
    logic          full, empty;
    logic [AW-1:0] lookup_addr;
    logic [N-1:0]  lookup_match;
    logic          lookup_hit;
    logic          mem_valid, mem_ready, mem_last;
    logic [AW-1:0] mem_addr;
    logic [2:0]    mem_beat;
    logic [BW-1:0] mem_data;

    always #10 clk = ~clk;

    evict_wb_buffer u_dut (
        .clk(clk), .rst_n(rst_n),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .full(full), .empty(empty),
        .lookup_addr(lookup_addr), .lookup_match(lookup_match), .lookup_hit(lookup_hit),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_beat(mem_beat), .mem_last(mem_last), .mem_data(mem_data)
    );

    typedef struct {
        logic [AW-1:0] a;
        logic [LW-1:0] d;
        int            slot;
    } line_t;

    line_t q[$];
    int    m_beat;
    int    m_slot;
    int    n_chk;
    int    n_fail;
    bit    finished;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] mkline(input int seed);
        logic [LW-1:0] v;
        for (int i = 0; i < LW / 32; i++) begin
            v[i*32 +: 32] = (seed * 32'h9E37_79B9) ^ (i * 32'h0101_0101) ^ 32'h5A00_0000;
        end
        return v;
    endfunction

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Called just after a falling edge with inputs set; compares, updates the model,
    // and returns at the next falling edge.
    task automatic cycle();
        logic [N-1:0] em;
        bit           ok;
        #5;
        chk("R3 empty", 64'(empty), 64'(q.size() == 0));
        chk("R3 full", 64'(full), 64'(q.size() == N));
        chk("R4 mem_valid", 64'(mem_valid), 64'(q.size() > 0));
        if (q.size() > 0) begin
            chk("R4 mem_addr", 64'(mem_addr), 64'(q[0].a));
            chk("R5 mem_beat", 64'(mem_beat), 64'(m_beat));
            chk("R5 mem_last", 64'(mem_last), 64'(m_beat == NB - 1));
            chk("R5 mem_data", mem_data, q[0].d[m_beat*BW +: BW]);
        end
        em = '0;
        foreach (q[i]) begin
            if (q[i].a == lookup_addr) em[q[i].slot] = 1'b1;
        end
        chk("R7 lookup_match", 64'(lookup_match), 64'(em));
        chk("R7 lookup_hit", 64'(lookup_hit), 64'(em != '0));
        ok = fill_valid && (q.size() < N);
        if (q.size() > 0 && mem_ready) begin
            if (m_beat == NB - 1) begin
                void'(q.pop_front());
                m_beat = 0;
            end else begin
                m_beat++;
            end
        end
        if (ok) begin
            q.push_back('{a: fill_addr, d: fill_data, slot: m_slot});
            m_slot = (m_slot + 1) % N;
        end
        @(negedge clk);
    endtask

    task automatic set_fill(input bit v, input int seed);
        fill_valid = v;
        fill_addr  = AW'(seed);
        fill_data  = mkline(seed);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        logic [BW-1:0] held;
        logic [AW-1:0] last_addr;
        bit            was_last;
        n_chk = 0; n_fail = 0; finished = 1'b0;
        m_beat = 0; m_slot = 0;
        rst_n = 1'b0; mem_ready = 1'b0; lookup_addr = '0;
        set_fill(1'b0, 0);
        repeat (3) @(negedge clk);
        chk("R1 empty in reset", 64'(empty), 64'd1);
        chk("R1 full in reset", 64'(full), 64'd0);
        chk("R1 mem_valid in reset", 64'(mem_valid), 64'd0);
        chk("R1 hit in reset", 64'(lookup_hit), 64'd0);
        rst_n = 1'b1;
        cycle();

        // Load with memory stalled; compare in the same cycle must miss (R8)
        set_fill(1'b1, 'h100);
        lookup_addr = AW'('h100);
        #1 chk("R8 same-cycle load not visible", 64'(lookup_hit), 64'd0);
        cycle();
        set_fill(1'b0, 0);
        #1 chk("R2 first load in slot 0", 64'(lookup_match), 64'h01);
        chk("R2 not empty after load", 64'(empty), 64'd0);
        cycle();
        for (int k = 1; k < N; k++) begin
            set_fill(1'b1, 'h100 + k);
            lookup_addr = AW'('h100 + k - 1);
            cycle();
        end
        // Extra load offered while full (R3)
        set_fill(1'b1, 'h1FF);
        cycle();
        set_fill(1'b0, 0);
        lookup_addr = AW'('h1FF);
        #1 chk("R3 refused load absent", 64'(lookup_hit), 64'd0);
        cycle();

        // Stall check (R6)
        held = mem_data;
        cycle();
        chk("R6 data held under stall", mem_data, held);
        cycle();

        // Irregular drain with head tracking (R4, R5, R9)
        was_last = 1'b0;
        last_addr = '0;
        for (int c = 0; c < 200 && !empty; c++) begin
            if (was_last) begin
                lookup_addr = last_addr;
                #1 chk("R9 drained slot stops matching", 64'(lookup_hit), 64'd0);
            end
            mem_ready = (c % 3) != 0;
            lookup_addr = mem_addr;
            was_last = mem_last && mem_ready;
            last_addr = mem_addr;
            if (was_last) begin
                #1 chk("R9 slot matches through final beat", 64'(lookup_hit), 64'd1);
            end
            cycle();
        end
        mem_ready = 1'b0;

        // Final beat coinciding with a load offered while full (R10)
        for (int k = 0; k < N; k++) begin
            set_fill(1'b1, 'h200 + k);
            cycle();
        end
        mem_ready = 1'b1;
        set_fill(1'b0, 0);
        while (!mem_last) cycle();
        chk("R10 full before final beat", 64'(full), 64'd1);
        set_fill(1'b1, 'h2AA);
        cycle();
        set_fill(1'b0, 0);
        mem_ready = 1'b0;
        lookup_addr = AW'('h2AA);
        #1 chk("R10 load refused at final beat", 64'(lookup_hit), 64'd0);
        chk("R10 not full after final beat", 64'(full), 64'd0);
        cycle();

        // Mixed random traffic with repeating addresses
        for (int c = 0; c < 4000; c++) begin
            set_fill(($urandom % 4) == 0, 'h300 + ($urandom % 12));
            mem_ready   = ($urandom % 2) == 0;
            lookup_addr = AW'('h300 + ($urandom % 12));
            cycle();
        end
        set_fill(1'b0, 0);
        mem_ready = 1'b1;
        for (int c = 0; c < 100 && q.size() > 0; c++) cycle();
        chk("R3 empty after final drain", 64'(empty), 64'd1);
        report();
    end
endmodule